// File: doc/BRIEF.md
# Sequenced Ripple Byte Queue

This block is a small first-in first-out queue made of a chain of byte-wide stages. Data arrives on a four-phase push channel at the head stage and leaves on a four-phase push channel from the tail stage. A single controller walks the stages through one fixed loop. First it offers the tail value to the consumer. Next it moves every stage one place toward the tail, beginning at the tail end, one move per clock. Last it accepts one new byte into the head stage. Then the loop repeats.

Only one transfer happens at any time. A full loop therefore costs one channel handshake on each side plus one clock for each internal move. All stages clear on reset, so the first DEPTH values offered on the output are zeros. After those, the bytes come out in the order they went in. The current step of the loop is visible on a port so that an observer can follow the sequence.

Top module: `ripple_reg`

## Requirements
- R1: While reset is asserted and right after it is released, every stage holds zero, step_o is 0 (the output step), in_ack is low, and out_req is high while out_data is 0.
- R2: In the output step, out_req stays high until out_ack is sampled high, and goes low on the next clock after that.
- R3: The loop leaves the output step only on the clock after out_ack has been sampled low following its rise. Until then step_o stays 0.
- R4: step_o values 1 to DEPTH-1 are the shift steps, and each lasts exactly one clock. Step k copies stage DEPTH-k from stage DEPTH-k-1, so the stages are moved tail first. Step k+1 follows step k.
- R5: step_o equal to DEPTH is the input step. When in_req is sampled high in that step, the byte on in_data is stored into the head stage and in_ack rises on the same clock. When in_req is then sampled low, in_ack falls and step_o returns to 0.
- R6: in_ack and out_req are never high at the same time.
- R7: The sequence of bytes delivered on the output equals DEPTH zeros followed by the input bytes in arrival order.
- R8: A request on in_req outside the input step is ignored: in_ack stays low and no byte is taken until the loop reaches step DEPTH.
- R9: out_data does not change while out_req stays high.
- R10: When both channel partners respond on the first clock they can, one loop lasts DEPTH+3 clocks between successive rises of out_req: 2 for the output handshake, DEPTH-1 for the shifts, and 2 for the input handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | 1 | Producer request, data valid while high |
| in_data | input | W | Byte offered by the producer |
| in_ack | output | 1 | Acknowledge to the producer |
| out_req | output | 1 | Request to the consumer, data valid while high |
| out_data | output | W | Tail stage value offered to the consumer |
| out_ack | input | 1 | Acknowledge from the consumer |
| step_o | output | $clog2(DEPTH+1) | Current loop step: 0 output, 1..DEPTH-1 shift, DEPTH input |

## Verification
The two channels share no clock edge by design, but a producer that raises in_req early makes a pending input coincide with the output handshake and the shift steps. The bench provokes this with a producer that reasserts its request immediately and a consumer that delays its acknowledge over a sweep of response delays. It judges the result by checking every clock that in_ack stays low outside the input step and that the byte stream seen by the consumer still matches the leading zeros followed by the inputs in order.

// File: rtl/rr_pkg.sv
package rr_pkg;

  // Stage written during shift step k of a queue with n stages.
  function automatic int unsigned dst_of(input int unsigned step, input int unsigned n);
    return n - step;
  endfunction

  // Clocks in one loop when both partners answer at once.
  function automatic int unsigned loop_clocks(input int unsigned n);
    return n + 3;
  endfunction

endpackage

// File: rtl/rr_seq.sv
module rr_seq #(
  parameter int N = 4,
  localparam int STEP_W = $clog2(N + 1),
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  input  logic              out_ack,
  output logic              out_req,
  output logic              in_ack,
  output logic              shift_en,
  output logic [IDX_W-1:0]  shift_dst,
  output logic              cap_en,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N);

  logic hold;  // waiting for the partner's falling edge

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      hold <= 1'b0;
    end else if (step == '0) begin
      if (!hold && out_ack) begin
        hold <= 1'b1;
      end else if (hold && !out_ack) begin
        hold <= 1'b0;
        step <= STEP_W'(1);
      end
    end else if (step == LAST) begin
      if (!hold && in_req) begin
        hold <= 1'b1;
      end else if (hold && !in_req) begin
        hold <= 1'b0;
        step <= '0;
      end
    end else begin
      step <= step + 1'b1;
    end
  end

  always_comb begin
    out_req   = (step == '0) && !hold;
    in_ack    = (step == LAST) && hold;
    cap_en    = (step == LAST) && !hold && in_req;
    shift_en  = (step != '0) && (step != LAST);
    shift_dst = IDX_W'(rr_pkg::dst_of(int'(unsigned'(step)), N));
  end

endmodule

// File: rtl/rr_store.sv
module rr_store #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [IDX_W-1:0] shift_dst,
  input  logic             cap_en,
  input  logic [W-1:0]     cap_data,
  output logic [W-1:0]     tail
);
  logic [W-1:0] stg [N];

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg[i] <= '0;
        else if (cap_en) stg[i] <= cap_data;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          stg[i] <= '0;
        else if (shift_en && (shift_dst == IDX_W'(i)))
          stg[i] <= stg[i-1];
      end
    end
  end

  assign tail = stg[N-1];

endmodule

// File: rtl/ripple_reg.sv
module ripple_reg #(
  parameter int W = 8,
  parameter int DEPTH = 4,
  localparam int STEP_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  input  logic [W-1:0]      in_data,
  output logic              in_ack,
  output logic              out_req,
  output logic [W-1:0]      out_data,
  input  logic              out_ack,
  output logic [STEP_W-1:0] step_o
);
  // Internal events, named for the checker.
  logic             shift_en;
  logic [IDX_W-1:0] shift_dst;
  logic             cap_en;

  rr_seq #(.N(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .out_ack(out_ack),
    .out_req(out_req), .in_ack(in_ack), .shift_en(shift_en),
    .shift_dst(shift_dst), .cap_en(cap_en), .step(step_o)
  );

  rr_store #(.W(W), .N(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_dst(shift_dst),
    .cap_en(cap_en), .cap_data(in_data), .tail(out_data)
  );

endmodule

// File: rtl/rr_check.sv
module rr_check #(
  parameter int W = 8,
  parameter int DEPTH = 4,
  localparam int STEP_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_req,
  input logic              in_ack,
  input logic              out_req,
  input logic [W-1:0]      out_data,
  input logic              out_ack,
  input logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(DEPTH);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req);

  assert_req_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && out_ack) |=> !out_req);

  assert_wait_ack_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == '0 && !out_req && out_ack) |=> (step_o == '0));

  assert_shift_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != '0 && step_o != LAST) |=> (step_o == $past(step_o) + 1'b1));

  assert_ack_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o == LAST && in_req && !in_ack) |=> in_ack);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ack && out_req));

  assert_no_early_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o != LAST) |-> !in_ack);

  assert_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && $past(out_req)) |-> (out_data == $past(out_data)));

endmodule

bind ripple_reg rr_check #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
  .out_req(out_req), .out_data(out_data), .out_ack(out_ack), .step_o(step_o)
);

// File: tb/sim_ripple_reg.sv
`timescale 1ns/1ps
module sim_ripple_reg;
  localparam int W = 8;
  localparam int N = 4;
  localparam int SW = $clog2(N + 1);
  localparam int K = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_req = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ack;
  logic          out_req;
  logic [W-1:0]  out_data;
  logic          out_ack = 1'b0;
  logic [SW-1:0] step_o;

  int checks = 0;
  int fails = 0;
  int combo = 0;
  int pdly = 0;
  int cdly = 0;
  bit mon_on = 1'b0;
  bit zero_mode = 1'b0;

  always #5 clk = ~clk;

  ripple_reg #(.W(W), .DEPTH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
    .in_ack(in_ack), .out_req(out_req), .out_data(out_data),
    .out_ack(out_ack), .step_o(step_o)
  );

  function automatic logic [W-1:0] val(input int c, input int i);
    return W'((c * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (combo %0d)", req, act, exp, combo);
    end
  endtask

  // Per-clock monitor: R4 step order, R8 ignored early requests, R6, R10 loop length.
  int  prev_step = 0;
  bit  prev_req = 1'b0;
  bit  have_prev = 1'b0;
  int  cnt = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_step >= 1 && prev_step <= N - 1)
        check(int'(step_o) == prev_step + 1, "R4", int'(step_o), prev_step + 1);
      if (int'(step_o) != N)
        check(in_ack == 1'b0, "R8", int'(in_ack), 0);
      check(!(in_ack && out_req), "R6", int'(in_ack && out_req), 0);
      cnt++;
      if (out_req && !prev_req) begin
        if (zero_mode && have_prev)
          check(cnt == N + 3, "R10", cnt, N + 3);  // loop also exercises R5 timing
        have_prev = 1'b1;
        cnt = 0;
      end
      prev_step = int'(step_o);
      prev_req = out_req;
    end
  end

  task automatic producer();
    for (int i = 0; i < K; i++) begin
      repeat (pdly) @(negedge clk);
      in_data = val(combo, i);
      in_req = 1'b1;
      do @(negedge clk); while (!in_ack);
      in_req = 1'b0;
      do @(negedge clk); while (in_ack);
    end
  endtask

  task automatic consumer();
    for (int i = 0; i < K; i++) begin
      int exp;
      while (!out_req) @(negedge clk);
      repeat (cdly) begin
        @(negedge clk);
        check(out_req == 1'b1, "R2", int'(out_req), 1);
      end
      exp = (i < N) ? 0 : int'(val(combo, i - N));
      check(int'(out_data) == exp, "R7", int'(out_data), exp);
      out_ack = 1'b1;
      @(negedge clk);
      check(out_req == 1'b0, "R2", int'(out_req), 0);
      repeat (cdly) begin
        @(negedge clk);
        check(step_o == '0, "R3", int'(step_o), 0);
      end
      out_ack = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 9; c++) begin
      combo = c;
      pdly = c / 3;
      cdly = c % 3;
      zero_mode = (c == 0);
      mon_on = 1'b0;
      in_req = 1'b0;
      out_ack = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check(step_o == '0 && !in_ack && out_req && out_data == '0, "R1",
            int'({step_o, in_ack, out_req, out_data}), int'({3'b000, 1'b0, 1'b1, 8'h00}));
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(step_o == '0 && !in_ack && out_req && out_data == '0, "R1",
            int'({step_o, in_ack, out_req, out_data}), int'({3'b000, 1'b0, 1'b1, 8'h00}));
      prev_step = 0;
      prev_req = 1'b1;
      have_prev = 1'b1;
      cnt = 0;
      mon_on = 1'b1;
      fork
        producer();
        consumer();
      join
      // R5: after the last input handshake the loop has returned to output step.
      repeat (2) @(negedge clk);
      check(!in_ack, "R5", int'(in_ack), 0);
    end
    mon_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule